// File: doc/BRIEF.md
# Program Counter Sequencer with Circular Return Stack

This block produces the program counter of a small 8-bit microcontroller core. Every cycle it takes one-cycle strobes from instruction decode and moves a 13-bit program counter. The strobes are sequential advance, subroutine call, interrupt entry, return, and a software write to the low byte of the counter. Calls and interrupt entry save a return address on an internal eight-entry stack. All three kinds of return (plain, with literal, from interrupt) arrive on the same return strobe and restore the most recently saved address.

The stack pointer is private to the block. It is never visible to software and wraps silently, with no overflow or underflow indication. A low-byte write always takes the five upper counter bits from an external page latch input. With the add qualifier, a low-byte write performs a computed jump: the data is added to the current low byte, and the carry is discarded, so a jump table stays inside its 256-word page.

Top module: `pcseq_top`

## Requirements
- R1: While rst_n is low, pc_o is 0x000 and the stack pointer returns to slot 0. Stack contents are not cleared.
- R2: With only step_i high, pc_o becomes pc_o+1 at the next clock edge, wrapping from 0x1FFF to 0x000.
- R3: With call_i high and irq_i low, pc_o becomes target_i, and pc_o+1 (13-bit wrap) is saved on the stack.
- R4: With irq_i high, pc_o becomes 0x004, and the current pc_o (the pre-empted address) is saved on the stack.
- R5: With ret_i as the winning strobe, pc_o becomes the most recently saved address that has not yet been restored (last in, first out).
- R6: The stack has eight 13-bit slots and a pointer that counts modulo 8. The ninth save overwrites the first, the tenth overwrites the second, and so on. Restoring more than was saved returns whatever slot the wrapped pointer selects. No flag is raised.
- R7: With lowwr_i as the winning strobe and lowadd_i low, pc_o[7:0] becomes wdata_i and pc_o[12:8] becomes latch_i[4:0]. latch_i[7:5] has no effect.
- R8: With lowwr_i as the winning strobe and lowadd_i high, pc_o[7:0] becomes (pc_o[7:0]+wdata_i) mod 256 and pc_o[12:8] becomes latch_i[4:0]. The carry out of bit 7 is dropped.
- R9: When several strobes are high together, exactly one update happens, with priority irq_i, then call_i, then ret_i, then lowwr_i, then step_i.
- R10: With no strobe high, pc_o and the stack are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance to the next sequential address |
| call_i | input | 1 | Subroutine call strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| ret_i | input | 1 | Return strobe (all return kinds) |
| lowwr_i | input | 1 | Software write to the counter low byte |
| lowadd_i | input | 1 | Qualifies lowwr_i as a computed jump (add rather than load) |
| target_i | input | 13 | Call destination address |
| wdata_i | input | 8 | Low-byte write data or computed-jump offset |
| latch_i | input | 8 | Page latch contents; bits 4:0 supply the upper counter bits |
| pc_o | output | 13 | Current program counter |

## Verification
Every strobe takes effect at the first rising edge after it is driven, so pc_o carries the result one cycle after the stimulus. An address saved by a call or an interrupt becomes visible on pc_o only in the cycle after a later return. The bench drives each stimulus on a falling edge and compares pc_o on the next falling edge against a model that it updates arithmetically. A return is checked one cycle after the return strobe, and any earlier saves are carried in the bench's own eight-slot model. Sweeps cover every page-latch value, every computed-jump offset and all 64 strobe combinations, and the save and restore runs go past the wrap point in both directions.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_LOAD_LOW,
        OP_ADD_LOW,
        OP_RETURN,
        OP_CALL,
        OP_VECTOR
    } seq_op_e;

endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic    irq_i,
    input  logic    call_i,
    input  logic    ret_i,
    input  logic    lowwr_i,
    input  logic    lowadd_i,
    input  logic    step_i,
    output seq_op_e op_o,
    output logic    save_o,
    output logic    restore_o
);

    // Fixed priority: vector, call, return, low write, step (R9)
    always_comb begin
        if (irq_i)        op_o = OP_VECTOR;
        else if (call_i)  op_o = OP_CALL;
        else if (ret_i)   op_o = OP_RETURN;
        else if (lowwr_i) op_o = lowadd_i ? OP_ADD_LOW : OP_LOAD_LOW;
        else if (step_i)  op_o = OP_STEP;
        else              op_o = OP_HOLD;
        save_o    = (op_o == OP_VECTOR) || (op_o == OP_CALL);
        restore_o = (op_o == OP_RETURN);
    end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         save_i,
    input  logic         restore_i,
    input  logic [W-1:0] save_data_i,
    output logic [W-1:0] top_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] sp;
    } ptr_state_t;

    ptr_state_t   st_d, st_q;
    logic [W-1:0] slot_q [DEPTH];

    // Pointer wraps modulo DEPTH, no flags (R6)
    always_comb begin
        st_d = st_q;
        if (save_i)         st_d.sp = st_q.sp + 1'b1;
        else if (restore_i) st_d.sp = st_q.sp - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Contents are deliberately not reset (R1)
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (save_i && (st_q.sp == PTR_W'(g))) slot_q[g] <= save_data_i;
            end
        end
    endgenerate

    assign top_o = slot_q[st_q.sp - 1'b1];

    // A save makes its data the top entry (R5)
    assert_save_on_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        save_i |=> (top_o == $past(save_data_i)));

    // A save followed by a restore leaves the previous top visible again (R6)
    assert_restore_undoes_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i ##1 restore_i) |=> (top_o === $past(top_o, 2)));

    assert_exclusive_ops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(save_i && restore_i));

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int unsigned PC_W   = 13,
    parameter int unsigned LOW_W  = 8,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned VECTOR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             call_i,
    input  logic             irq_i,
    input  logic             ret_i,
    input  logic             lowwr_i,
    input  logic             lowadd_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [LOW_W-1:0] wdata_i,
    input  logic [LOW_W-1:0] latch_i,
    output logic [PC_W-1:0]  pc_o
);

    localparam int unsigned HI_W = PC_W - LOW_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_state_t;

    seq_state_t      st_d, st_q;
    seq_op_e         op;
    logic            save, restore;
    logic [PC_W-1:0] save_data, stack_top, pc_inc;
    logic [LOW_W-1:0] low_sum;

    pcseq_arbiter u_arb (
        .irq_i     (irq_i),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .lowwr_i   (lowwr_i),
        .lowadd_i  (lowadd_i),
        .step_i    (step_i),
        .op_o      (op),
        .save_o    (save),
        .restore_o (restore)
    );

    pcseq_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_i      (save),
        .restore_i   (restore),
        .save_data_i (save_data),
        .top_o       (stack_top)
    );

    always_comb begin
        pc_inc    = st_q.pc + 1'b1;
        low_sum   = st_q.pc[LOW_W-1:0] + wdata_i;   // carry dropped (R8)
        save_data = (op == OP_VECTOR) ? st_q.pc : pc_inc;
        st_d      = st_q;
        unique case (op)
            OP_VECTOR:   st_d.pc = PC_W'(VECTOR);
            OP_CALL:     st_d.pc = target_i;
            OP_RETURN:   st_d.pc = stack_top;
            OP_LOAD_LOW: st_d.pc = {latch_i[HI_W-1:0], wdata_i};
            OP_ADD_LOW:  st_d.pc = {latch_i[HI_W-1:0], low_sum};
            OP_STEP:     st_d.pc = pc_inc;
            default:     st_d.pc = st_q.pc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    assert_vector_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> (pc_o == PC_W'(VECTOR)));

    assert_call_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !irq_i) |=> (pc_o == $past(target_i)));

    assert_page_from_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lowwr_i && !irq_i && !call_i && !ret_i)
        |=> (pc_o[PC_W-1:LOW_W] == $past(latch_i[HI_W-1:0])));

    assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !irq_i && !call_i && !ret_i && !lowwr_i)
        |=> (pc_o == $past(pc_o) + 1'b1));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_i || irq_i || call_i || ret_i || lowwr_i) |=> $stable(pc_o));

endmodule

// File: tb/pcseq_top_tb_top.sv
module pcseq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 0, call_i = 0, irq_i = 0, ret_i = 0, lowwr_i = 0, lowadd_i = 0;
    logic [12:0] target_i = '0;
    logic [7:0]  wdata_i = '0, latch_i = '0;
    logic [12:0] pc_o;

    int checks = 0;
    int errors = 0;

    logic [12:0] m_pc;
    logic [12:0] m_stk [8];
    logic [2:0]  m_sp;

    always #2 clk = ~clk;   // 250 MHz

    pcseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .call_i(call_i), .irq_i(irq_i),
        .ret_i(ret_i), .lowwr_i(lowwr_i), .lowadd_i(lowadd_i), .target_i(target_i),
        .wdata_i(wdata_i), .latch_i(latch_i), .pc_o(pc_o)
    );

    task automatic check_pc(input string tag);
        checks++;
        if (pc_o !== m_pc) begin
            errors++;
            $display("FAIL %s: pc_o actual 0x%04h expected 0x%04h", tag, pc_o, m_pc);
        end
    endtask

    // Called at a falling edge; applies strobes, models, checks at the next falling edge.
    task automatic do_cycle(input logic irq, input logic call, input logic ret,
                            input logic lw, input logic la, input logic st,
                            input logic [12:0] tgt, input logic [7:0] wd,
                            input logic [7:0] lt, input string tag);
        irq_i = irq; call_i = call; ret_i = ret; lowwr_i = lw; lowadd_i = la;
        step_i = st; target_i = tgt; wdata_i = wd; latch_i = lt;
        if (irq) begin
            m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; m_pc = 13'h004;
        end else if (call) begin
            m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; m_pc = tgt;
        end else if (ret) begin
            m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp];
        end else if (lw) begin
            m_pc = {lt[4:0], la ? 8'(m_pc[7:0] + wd) : wd};
        end else if (st) begin
            m_pc = m_pc + 13'd1;
        end
        @(negedge clk);
        check_pc(tag);
        irq_i = 0; call_i = 0; ret_i = 0; lowwr_i = 0; lowadd_i = 0; step_i = 0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        m_pc = '0; m_sp = '0;
        @(negedge clk); @(negedge clk);
        check_pc("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_pc("R1 after release");
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        apply_reset();

        // R2: sequential advance
        for (int i = 0; i < 20; i++) do_cycle(0,0,0,0,0,1, '0, '0, '0, "R2 step");

        // R7: full sweep of latch values, upper latch bits ignored
        for (int v = 0; v < 256; v++)
            do_cycle(0,0,0,1,0,0, '0, 8'(v) ^ 8'h5A, 8'(v), "R7 low write");

        // R2: wrap at the top of the address space
        do_cycle(0,0,0,1,0,0, '0, 8'hFE, 8'hFF, "R7 set 0x1FFE");
        do_cycle(0,0,0,0,0,1, '0, '0, '0, "R2 to 0x1FFF");
        do_cycle(0,0,0,0,0,1, '0, '0, '0, "R2 wrap to 0x000");

        // R3/R6: ten calls overrun the eight slots
        for (int k = 0; k < 10; k++)
            do_cycle(0,1,0,0,0,0, 13'(13'h100 + k * 13'h37), '0, '0, "R3 call");
        // R5/R6: twelve returns walk past the wrap
        for (int k = 0; k < 12; k++) do_cycle(0,0,1,0,0,0, '0, '0, '0, "R6 wrapped return");

        // R4: interrupts interleaved with steps, then restored
        for (int k = 0; k < 4; k++) begin
            do_cycle(0,0,0,0,0,1, '0, '0, '0, "R2 step");
            do_cycle(1,0,0,0,0,0, '0, '0, '0, "R4 vector");
        end
        for (int k = 0; k < 4; k++) do_cycle(0,0,1,0,0,0, '0, '0, '0, "R5 return");

        // R8: computed jump sweep, carry stays in the page
        do_cycle(0,0,0,1,0,0, '0, 8'hF0, 8'h0A, "R7 set page");
        for (int v = 0; v < 256; v++)
            do_cycle(0,0,0,1,1,0, '0, 8'(v), 8'h0A, "R8 computed add");

        // R9: every strobe combination
        for (int c = 0; c < 64; c++)
            do_cycle(c[5], c[4], c[3], c[2], c[1], c[0], 13'(13'h0A5 + c * 13'h61),
                     8'(c * 7), 8'(c * 3), "R9 priority");

        // R10: idle cycles hold
        for (int i = 0; i < 5; i++) do_cycle(0,0,0,0,0,0, 13'h1234, 8'h77, 8'h1F, "R10 hold");

        // R1: reset mid-run, then a save/restore pair
        do_cycle(0,0,0,0,0,1, '0, '0, '0, "R2 step");
        apply_reset();
        do_cycle(0,1,0,0,0,0, 13'h0321, '0, '0, "R3 call after reset");
        do_cycle(0,0,1,0,0,0, '0, '0, '0, "R5 return after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule